// File: doc/BRIEF.md
# Serial Absolute Encoder Frame Slave

This block is the sensor end of a point-to-point, clocked serial link for absolute position encoders. A controller drives a link clock into the block; the block answers on a single data line. The link clock and data line idle high. A frame begins with the first rising edge of the link clock. At that edge the block freezes the position word and the error and warning flags. At the second rising edge it pulls data low to acknowledge. It then holds data low for a fixed number of link-clock cycles while the sample is prepared.

After preparation the block sends, one bit per rising edge, a high start bit and then a control echo bit. The echo bit repeats the control bit it captured after the previous frame. Next come the position bits, the error flag, the warning flag and a 6-bit check code. After the frame the controller holds the link clock steady for a timeout. The level it holds is captured as the control bit for the next frame's echo. The link clock is sampled on the block's own clock `clk` and is assumed to be synchronous to it already.

Top module: `enc_frame_slave`

## Requirements
- R1: After reset, and whenever the block is idle, `link_dat` is 1. The captured control bit resets to 0.
- R2: `pos_in`, `err_in` and `warn_in` are captured at the first rising edge of `link_clk` in a frame. Later changes to them do not affect that frame.
- R3: At the second rising edge of `link_clk`, `link_dat` goes to 0 (acknowledge).
- R4: For the next `PREP_CYC` rising edges, `link_dat` stays 0 (busy).
- R5: At the rising edge after the busy phase, `link_dat` is 1 for one bit (start bit).
- R6: The bit after the start bit equals the control bit captured after the most recent completed frame. It is 0 if no frame has completed since reset.
- R7: After the echo bit come the position bits, most significant first, then the error flag, then the warning flag, one bit per rising edge.
- R8: Six check bits follow, most significant first and inverted. They are the remainder of polynomial x^6+x+1 (initial value 0) over the position bits (MSB first), error and warning.
- R9: `link_dat` changes only in the `clk` cycle that registers a rising edge of `link_clk`, or a timeout event. It never changes on a falling edge.
- R10: The rising edge after the last check bit drives `link_dat` to 0. Further rising edges are then ignored. When `link_clk` has been stable for `TIMEOUT_CYC` cycles of `clk`, its level becomes the control bit. If that level is 1, `link_dat` returns to 1 and the block goes idle. If it is 0, `link_dat` stays 0 until `link_clk` has again been stable high for `TIMEOUT_CYC` cycles.
- R11: If `link_clk` stays high for `TIMEOUT_CYC` cycles in the middle of a frame, the block aborts: `link_dat` returns to 1 and the captured control bit is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the link clock |
| rst | input | 1 | Asynchronous active-high reset |
| link_clk | input | 1 | Link clock from the controller, idle high |
| pos_in | input | POS_W | Live position word |
| err_in | input | 1 | Live error flag |
| warn_in | input | 1 | Live warning flag |
| link_dat | output | 1 | Serial data to the controller, idle high |

## Verification
Frames are sent with position words of all zeros, all ones and mixed patterns. Mixed patterns separate bit order and check-code errors that uniform words hide. The error and warning flags cover all four combinations. Frames end alternately with the clock held high and held low, which tells a real echo of the control bit apart from a constant. The bench changes the inputs after the first edge of a frame, toggles the clock while a low control level is held, and aborts a frame by stopping the clock high. It then sends a following frame to show that the abort left the echo bit unchanged.

// File: rtl/efs_pkg.sv
package efs_pkg;
  localparam int CRC_W = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'h03;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARMED,
    ST_BUSY,
    ST_START,
    ST_CDS,
    ST_SHIFT,
    ST_END,
    ST_TAIL,
    ST_HOLD
  } efs_state_t;
endpackage

// File: rtl/efs_line_mon.sv
module efs_line_mon #(
  parameter int TIMEOUT_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic link_clk,
  output logic rise,
  output logic tout_evt
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] CNT_FIRE = CW'(TIMEOUT_CYC - 1);

  logic          prev_q;
  logic [CW-1:0] stab_q;
  logic          changed;

  assign changed  = (link_clk != prev_q);
  assign rise     = link_clk & ~prev_q;
  assign tout_evt = ~changed && (stab_q == CNT_FIRE);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev_q <= 1'b1;
      stab_q <= '0;
    end else begin
      prev_q <= link_clk;
      if (changed)
        stab_q <= '0;
      else if (stab_q != CNT_MAX)
        stab_q <= stab_q + 1'b1;
    end
  end

  // R10: a stable stretch produces exactly one timeout event
  a_r10_tout_single: assert property (@(posedge clk) disable iff (rst)
    tout_evt |=> !tout_evt);
  // R9: a rising edge and a timeout never coincide
  a_r9_rise_excl_tout: assert property (@(posedge clk) disable iff (rst)
    !(rise && tout_evt));
endmodule

// File: rtl/efs_frame_shift.sv
module efs_frame_shift
  import efs_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [POS_W-1:0] pos,
  input  logic             err,
  input  logic             warn,
  output logic             bit_out
);
  localparam int DATA_W  = POS_W + 2;
  localparam int FRAME_W = DATA_W + CRC_W;

  function automatic logic [CRC_W-1:0] crc_calc(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = d[i] ^ r[CRC_W-1];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  logic [DATA_W-1:0]  payload;
  logic [FRAME_W-1:0] sh_q;

  assign payload = {pos, err, warn};
  assign bit_out = sh_q[FRAME_W-1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      sh_q <= '0;
    else if (load)
      sh_q <= {payload, ~crc_calc(payload)};
    else if (shift)
      sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  // R2: loading and shifting are never requested together
  a_r2_load_excl_shift: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));
endmodule

// File: rtl/enc_frame_slave.sv
module enc_frame_slave
  import efs_pkg::*;
#(
  parameter int POS_W       = 12,
  parameter int PREP_CYC    = 3,
  parameter int TIMEOUT_CYC = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_clk,
  input  logic [POS_W-1:0] pos_in,
  input  logic             err_in,
  input  logic             warn_in,
  output logic             link_dat
);
  localparam int FRAME_W   = POS_W + 2 + CRC_W;
  localparam int BITCW     = $clog2(FRAME_W);
  localparam int BUSYCW    = (PREP_CYC > 1) ? $clog2(PREP_CYC) : 1;
  localparam int PREP_LAST = (PREP_CYC > 0) ? PREP_CYC - 1 : 0;

  efs_state_t        state_q;
  logic [BUSYCW-1:0] busy_q;
  logic [BITCW-1:0]  bit_q;
  logic              cdm_q;
  logic              rise, tout_evt;
  logic              load, shift, sh_bit;

  efs_line_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
    .clk(clk), .rst(rst), .link_clk(link_clk),
    .rise(rise), .tout_evt(tout_evt)
  );

  assign load  = rise && (state_q == ST_IDLE);
  assign shift = rise && (state_q == ST_SHIFT);

  efs_frame_shift #(.POS_W(POS_W)) u_sh (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .pos(pos_in), .err(err_in), .warn(warn_in), .bit_out(sh_bit)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      busy_q   <= '0;
      bit_q    <= '0;
      cdm_q    <= 1'b0;
      link_dat <= 1'b1;
    end else if (tout_evt && state_q != ST_IDLE) begin
      if (link_clk) begin
        if (state_q == ST_TAIL) cdm_q <= 1'b1;
        state_q  <= ST_IDLE;
        link_dat <= 1'b1;
      end else if (state_q == ST_TAIL) begin
        cdm_q   <= 1'b0;
        state_q <= ST_HOLD;
      end
    end else if (rise) begin
      unique case (state_q)
        ST_IDLE:  state_q <= ST_ARMED;
        ST_ARMED: begin
          link_dat <= 1'b0;
          busy_q   <= '0;
          state_q  <= (PREP_CYC == 0) ? ST_START : ST_BUSY;
        end
        ST_BUSY: begin
          link_dat <= 1'b0;
          busy_q   <= busy_q + 1'b1;
          if (busy_q == BUSYCW'(PREP_LAST)) state_q <= ST_START;
        end
        ST_START: begin
          link_dat <= 1'b1;
          state_q  <= ST_CDS;
        end
        ST_CDS: begin
          link_dat <= cdm_q;
          bit_q    <= '0;
          state_q  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          link_dat <= sh_bit;
          bit_q    <= bit_q + 1'b1;
          if (bit_q == BITCW'(FRAME_W - 1)) state_q <= ST_END;
        end
        ST_END: begin
          link_dat <= 1'b0;
          state_q  <= ST_TAIL;
        end
        default: ;
      endcase
    end
  end

  // R1: idle means data high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> link_dat);
  // R3: acknowledge drives data low
  a_r3_ack_low: assert property (@(posedge clk) disable iff (rst)
    (rise && state_q == ST_ARMED) |=> !link_dat);
  // R4: data low throughout busy
  a_r4_busy_low: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY) |-> !link_dat);
  // R9: data moves only after a rising edge or a timeout
  a_r9_change_on_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_dat) |-> ($past(rise) || $past(tout_evt)));
  // R6: the control bit is captured only after a completed frame
  a_r6_cdm_from_tail: assert property (@(posedge clk) disable iff (rst)
    !$stable(cdm_q) |-> ($past(state_q) == ST_TAIL));
endmodule

// File: tb/enc_frame_slave_test.sv
module enc_frame_slave_test;
  localparam int POS_W = 12;
  localparam int PREP  = 3;
  localparam int TOUT  = 20;
  localparam int HALF  = 4;
  localparam int EDGES = PREP + POS_W + 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lclk = 1'b1;
  logic [POS_W-1:0] pos = '0;
  logic err = 1'b0, warn = 1'b0;
  logic dat;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  enc_frame_slave #(.POS_W(POS_W), .PREP_CYC(PREP), .TIMEOUT_CYC(TOUT)) uut (
    .clk(clk), .rst(rst), .link_clk(lclk),
    .pos_in(pos), .err_in(err), .warn_in(warn), .link_dat(dat)
  );

  // CRC by long division: remainder of (data * x^6) mod (x^6+x+1)
  function automatic int ref_crc(input longint d, input int w);
    longint m = d << 6;
    for (int i = w + 5; i >= 6; i--)
      if (m[i]) m = m ^ (longint'(7'b1000011) << (i - 6));
    return int'(m & 63);
  endfunction

  // behavioural reference model
  int m_mode = 0;  // 0 idle, 1 frame, 2 tail, 3 hold
  int m_edge = 0, m_cnt = 0;
  bit m_prev = 1, m_cdm = 0, exp_dat = 1;
  bit q_bits[$];
  string q_tags[$];
  string tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_prev = 1; m_cnt = 0; m_cdm = 0; exp_dat = 1; tag = "R1";
    end else begin
      bit r, t;
      int c;
      r = lclk && !m_prev;
      t = 0;
      if (lclk != m_prev) m_cnt = 0;
      else if (m_cnt < TOUT) begin m_cnt++; if (m_cnt == TOUT) t = 1; end
      m_prev = lclk;
      tag = (m_mode == 0) ? "R1" : "R9";
      if (t && m_mode != 0) begin
        if (lclk) begin
          tag = (m_mode == 1) ? "R11" : "R10";
          if (m_mode == 2) m_cdm = 1;
          m_mode = 0; exp_dat = 1;
        end else if (m_mode == 2) begin
          m_cdm = 0; m_mode = 3; tag = "R10";
        end
      end else if (r && m_mode == 0) begin
        m_mode = 1; m_edge = 1; tag = "R2";
        q_bits.delete(); q_tags.delete();
        c = ref_crc({pos, err, warn}, POS_W + 2);
        q_bits.push_back(1); q_tags.push_back("R5");
        q_bits.push_back(m_cdm); q_tags.push_back("R6");
        for (int i = POS_W - 1; i >= 0; i--) begin
          q_bits.push_back(pos[i]); q_tags.push_back("R7");
        end
        q_bits.push_back(err); q_tags.push_back("R7");
        q_bits.push_back(warn); q_tags.push_back("R7");
        for (int i = 5; i >= 0; i--) begin
          q_bits.push_back(!c[i]); q_tags.push_back("R8");
        end
        q_bits.push_back(0); q_tags.push_back("R10");
      end else if (r && m_mode == 1) begin
        m_edge++;
        if (m_edge == 2) begin exp_dat = 0; tag = "R3"; end
        else if (m_edge <= 2 + PREP) begin exp_dat = 0; tag = "R4"; end
        else begin
          exp_dat = q_bits.pop_front(); tag = q_tags.pop_front();
          if (q_bits.size() == 0) m_mode = 2;
        end
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string t);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: link_dat=%0b expected %0b", t, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) chk(dat, exp_dat, tag);

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [POS_W-1:0] p, input bit e, input bit w,
                       input bit cdm, input bit disturb);
    @(negedge clk); pos = p; err = e; warn = w;
    for (int k = 1; k <= EDGES; k++) begin
      lclk = 0; hold(HALF);
      lclk = 1; hold(HALF);
      if (disturb && k == 1) begin pos = ~p; err = !e; warn = !w; end  // R2
    end
    if (cdm) hold(TOUT + 10);
    else begin
      lclk = 0; hold(TOUT + 5);
      for (int k = 0; k < 2; k++) begin  // R10: rises ignored in hold
        lclk = 1; hold(HALF); lclk = 0; hold(HALF);
      end
      chk(dat, 1'b0, "R10 hold");
      lclk = 1; hold(TOUT + 10);
    end
    chk(dat, 1'b1, "R1 idle after frame");
  endtask

  initial begin
    hold(5); rst = 0;
    hold(2);
    chk(dat, 1'b1, "R1 reset");
    hold(10);
    frame(12'h000, 0, 0, 1, 0);
    frame(12'hFFF, 1, 1, 0, 0);
    frame(12'hA5C, 1, 0, 1, 1);
    // R11: abort after a few edges
    for (int k = 0; k < 6; k++) begin
      lclk = 0; hold(HALF); lclk = 1; hold(HALF);
    end
    hold(TOUT + 5);
    chk(dat, 1'b1, "R11 abort");
    frame(12'h3C1, 0, 1, 0, 0);
    frame(12'h5A3, 1, 1, 1, 1);
    frame(12'h801, 0, 0, 1, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule